// File: doc/BRIEF.md
# Packed String Compare Unit

The unit compares two 128-bit operands, a pattern and a subject, both holding either sixteen 8-bit or eight 16-bit characters. Every subject character is compared against every pattern character in a single evaluation, which is up to 256 byte comparisons side by side. One of four aggregation modes then folds that comparison matrix into one result bit per subject position: membership in a character set, membership in one of several ranges, equality position by position, or the start of a substring match. The mode is picked by an 8-bit control word.

The valid length of each operand is taken either from an explicit length input or from its first zero character. The per-position result can be inverted, either across every position or across the valid subject positions only. It is returned as the index of the lowest or highest set position, or as a mask. The mask is either packed into the low bits or expanded to one all-ones element per hit. A set of summary flags comes with every result. The result is captured in registers and reported one cycle after the request, together with a valid strobe.

Top module: `strcmp_unit`

## Requirements
- R1: Control bit 0 selects the character size: 0 gives sixteen 8-bit characters, 1 gives eight 16-bit characters. Character k occupies bits [8k+7:8k] or [16k+15:16k] of its operand.
- R2: With `use_len_i` = 1, an operand has min(length input, character count) valid characters, counted from position 0. A length of 31 therefore means the full operand.
- R3: With `use_len_i` = 0, an operand's valid characters are those below its first zero character. An operand with no zero character is valid in full.
- R4: Control bits [3:2] = 0 (set mode): a position is set when its subject character is valid and equals any valid pattern character.
- R5: Control bits [3:2] = 1 (range mode): pattern characters 2m and 2m+1 form the inclusive bounds low and high of a range, used only when both are valid. A valid subject character matches when it lies inside some range. The comparison is signed when control bit 1 is 1 and unsigned when it is 0.
- R6: Control bits [3:2] = 2 (positional mode): position i is set when both characters at i are valid and equal, or when both are invalid. It is clear when exactly one of them is valid.
- R7: Control bits [3:2] = 3 (substring mode): position i is set when, for every valid pattern character k with i+k below the character count, subject character i+k is valid and equals it. A pattern that runs past the end of the operand can still match at the tail.
- R8: Control bit 4 inverts the result. If control bit 5 is 0, every position below the character count is inverted. If bit 5 is 1, only the valid subject positions are inverted.
- R9: Control bit 7 = 0 (index form): `out_index_o` is the lowest set position when control bit 6 is 0, or the highest when it is 1. It equals the character count (16 or 8) when no position is set, and `out_mask_o` is zero.
- R10: Control bit 7 = 1 (mask form): with control bit 6 = 0 the result bit of position i goes to mask bit i. With control bit 6 = 1, each set position fills its whole character element with ones. `out_index_o` is zero in this form.
- R11: `out_flags_o` bit 0 is set when any result bit is set, bit 1 when the pattern is shorter than the character count, bit 2 when the subject is shorter, and bit 3 carries the result bit of position 0.
- R12: A request with `in_valid_i` high is reported with `out_valid_o` high on the next cycle. Outputs keep their values while no request arrives, and reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request strobe |
| ctrl_i | input | 8 | Control word (size, signedness, mode, polarity, selector, form) |
| use_len_i | input | 1 | 1: explicit lengths, 0: zero-terminated |
| pat_i | input | 128 | Pattern operand |
| pat_len_i | input | 5 | Explicit pattern length |
| subj_i | input | 128 | Subject operand |
| subj_len_i | input | 5 | Explicit subject length |
| out_valid_o | output | 1 | Result strobe, one cycle after request |
| out_index_o | output | 5 | Lowest/highest set position or character count |
| out_mask_o | output | 128 | Packed or expanded match mask |
| out_flags_o | output | 4 | {result bit 0, subject short, pattern short, any set} |

## Verification
Polarity inversion and the no-hit index fall in the same cycle when the subject is empty. With inversion limited to valid positions, an empty subject still yields no set bit and the index must equal the character count. With full inversion every position turns on and the index must drop to zero. The bench drives both cases back to back on a zero-leading subject and judges them against a behavioural model. It also drives substring mode with a pattern that hangs past the operand end, so the tail truncation and the validity rules decide the same positions together.

// File: rtl/strcmp_pkg.sv
package strcmp_pkg;

    typedef logic [16:0] chr_t;

    typedef enum logic [1:0] {
        AGG_SET   = 2'd0,
        AGG_RANGE = 2'd1,
        AGG_POS   = 2'd2,
        AGG_SUB   = 2'd3
    } agg_e;

    typedef struct packed {
        logic fmt_mask;
        logic sel_hi;
        logic pol_valid;
        logic pol_inv;
        agg_e agg;
        logic sgn;
        logic wide;
    } ctrl_t;

    typedef struct packed {
        logic lsb;
        logic subj_short;
        logic pat_short;
        logic any;
    } flags_t;

    // Extend a character to a common 17-bit form for signed or unsigned compare.
    function automatic chr_t widen(input logic [15:0] v, input logic wide, input logic sgn);
        if (wide) return {sgn & v[15], v};
        return {{9{sgn & v[7]}}, v[7:0]};
    endfunction

    function automatic logic chr_le(input chr_t a, input chr_t b, input logic sgn);
        if (sgn) return $signed(a) <= $signed(b);
        return a <= b;
    endfunction

endpackage

// File: rtl/strcmp_len.sv
module strcmp_len #(
    parameter int DATA_W = 128,
    parameter int NB     = DATA_W / 8,
    parameter int LEN_W  = $clog2(NB) + 1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              wide_i,
    input  logic              use_len_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [NB-1:0]     valid_o,
    output logic              short_o
);
    localparam int NW = NB / 2;

    always_comb begin
        logic hit_zero;
        logic ch_zero;
        logic in_lane;
        hit_zero = 1'b0;
        valid_o  = '0;
        for (int i = 0; i < NB; i++) begin
            in_lane = wide_i ? (i < NW) : 1'b1;
            ch_zero = wide_i ? (data_i[16*(i%NW) +: 16] == '0) : (data_i[8*i +: 8] == '0);
            if (in_lane && ch_zero) hit_zero = 1'b1;
            valid_o[i] = in_lane && (use_len_i ? (LEN_W'(i) < len_i) : !hit_zero);
        end
        short_o = wide_i ? !valid_o[NW-1] : !valid_o[NB-1];
    end

endmodule

// File: rtl/strcmp_agg.sv
module strcmp_agg
    import strcmp_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int NB     = DATA_W / 8
) (
    input  logic [DATA_W-1:0] pat_i,
    input  logic [DATA_W-1:0] subj_i,
    input  logic              wide_i,
    input  logic              sgn_i,
    input  agg_e              agg_i,
    input  logic              pol_inv_i,
    input  logic              pol_valid_i,
    input  logic [NB-1:0]     pvalid_i,
    input  logic [NB-1:0]     svalid_i,
    output logic [NB-1:0]     res_o
);
    localparam int NW = NB / 2;

    chr_t          pc  [NB];
    chr_t          sc  [NB];
    logic [NB-1:0] eqm [NB];
    logic [NB-1:0] raw;
    logic [NB-1:0] lane;

    // Character extraction for both operands.
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            if (wide_i) begin
                pc[i] = (i < NW) ? widen(pat_i[16*(i%NW) +: 16], 1'b1, sgn_i) : '0;
                sc[i] = (i < NW) ? widen(subj_i[16*(i%NW) +: 16], 1'b1, sgn_i) : '0;
            end else begin
                pc[i] = widen({8'h00, pat_i[8*i +: 8]}, 1'b0, sgn_i);
                sc[i] = widen({8'h00, subj_i[8*i +: 8]}, 1'b0, sgn_i);
            end
        end
    end

    // Full equality matrix: subject row i against pattern column j.
    always_comb begin
        for (int i = 0; i < NB; i++)
            for (int j = 0; j < NB; j++)
                eqm[i][j] = (sc[i] == pc[j]);
    end

    // Reduce the matrix per subject position according to the mode.
    always_comb begin
        int  cnt;
        logic ok;
        cnt  = wide_i ? NW : NB;
        raw  = '0;
        lane = '0;
        for (int i = 0; i < NB; i++) begin
            lane[i] = (i < cnt);
            ok = 1'b0;
            unique case (agg_i)
                AGG_SET: begin
                    for (int j = 0; j < NB; j++)
                        if (pvalid_i[j] && svalid_i[i] && eqm[i][j]) ok = 1'b1;
                end
                AGG_RANGE: begin
                    for (int m = 0; m < NB / 2; m++)
                        if (pvalid_i[2*m] && pvalid_i[2*m+1] && svalid_i[i] &&
                            chr_le(pc[2*m], sc[i], sgn_i) && chr_le(sc[i], pc[2*m+1], sgn_i))
                            ok = 1'b1;
                end
                AGG_POS: begin
                    if (svalid_i[i] && pvalid_i[i]) ok = eqm[i][i];
                    else                            ok = !svalid_i[i] && !pvalid_i[i];
                end
                AGG_SUB: begin
                    ok = 1'b1;
                    for (int k = 0; k < NB; k++) begin
                        if ((i + k) < cnt && pvalid_i[k]) begin
                            if (!svalid_i[i+k] || !eqm[i+k][k]) ok = 1'b0;
                        end
                    end
                end
                default: ok = 1'b0;
            endcase
            raw[i] = ok;
        end
        raw = raw & lane;
    end

    always_comb begin
        if (!pol_inv_i)      res_o = raw;
        else if (pol_valid_i) res_o = raw ^ svalid_i;
        else                  res_o = ~raw & lane;
    end

endmodule

// File: rtl/strcmp_pack.sv
module strcmp_pack #(
    parameter int DATA_W = 128,
    parameter int NB     = DATA_W / 8,
    parameter int IDX_W  = $clog2(NB) + 1
) (
    input  logic [NB-1:0]     res_i,
    input  logic              wide_i,
    input  logic              fmt_mask_i,
    input  logic              sel_hi_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] mask_o
);
    localparam int NW = NB / 2;

    always_comb begin
        idx_o = wide_i ? IDX_W'(NW) : IDX_W'(NB);
        if (sel_hi_i) begin
            for (int i = 0; i < NB; i++)
                if (res_i[i]) idx_o = IDX_W'(i);
        end else begin
            for (int i = NB - 1; i >= 0; i--)
                if (res_i[i]) idx_o = IDX_W'(i);
        end
        if (fmt_mask_i) idx_o = '0;
    end

    always_comb begin
        mask_o = '0;
        if (fmt_mask_i) begin
            if (!sel_hi_i) begin
                mask_o[NB-1:0] = res_i;
            end else if (wide_i) begin
                for (int i = 0; i < NW; i++) mask_o[16*i +: 16] = {16{res_i[i]}};
            end else begin
                for (int i = 0; i < NB; i++) mask_o[8*i +: 8] = {8{res_i[i]}};
            end
        end
    end

endmodule

// File: rtl/strcmp_unit.sv
module strcmp_unit
    import strcmp_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int NB     = DATA_W / 8,
    parameter int IDX_W  = $clog2(NB) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [7:0]        ctrl_i,
    input  logic              use_len_i,
    input  logic [DATA_W-1:0] pat_i,
    input  logic [IDX_W-1:0]  pat_len_i,
    input  logic [DATA_W-1:0] subj_i,
    input  logic [IDX_W-1:0]  subj_len_i,
    output logic              out_valid_o,
    output logic [IDX_W-1:0]  out_index_o,
    output logic [DATA_W-1:0] out_mask_o,
    output logic [3:0]        out_flags_o
);
    localparam int NW = NB / 2;

    ctrl_t             c;
    logic [NB-1:0]     pv, sv, res;
    logic              p_short, s_short;
    logic [IDX_W-1:0]  idx_d;
    logic [DATA_W-1:0] mask_d;
    flags_t            fl_d, fl_q;
    ctrl_t             cq;

    assign c = ctrl_t'(ctrl_i);

    strcmp_len #(.DATA_W(DATA_W), .NB(NB), .LEN_W(IDX_W)) u_plen (
        .data_i(pat_i), .wide_i(c.wide), .use_len_i(use_len_i), .len_i(pat_len_i),
        .valid_o(pv), .short_o(p_short));

    strcmp_len #(.DATA_W(DATA_W), .NB(NB), .LEN_W(IDX_W)) u_slen (
        .data_i(subj_i), .wide_i(c.wide), .use_len_i(use_len_i), .len_i(subj_len_i),
        .valid_o(sv), .short_o(s_short));

    strcmp_agg #(.DATA_W(DATA_W), .NB(NB)) u_agg (
        .pat_i(pat_i), .subj_i(subj_i), .wide_i(c.wide), .sgn_i(c.sgn), .agg_i(c.agg),
        .pol_inv_i(c.pol_inv), .pol_valid_i(c.pol_valid), .pvalid_i(pv), .svalid_i(sv),
        .res_o(res));

    strcmp_pack #(.DATA_W(DATA_W), .NB(NB), .IDX_W(IDX_W)) u_pack (
        .res_i(res), .wide_i(c.wide), .fmt_mask_i(c.fmt_mask), .sel_hi_i(c.sel_hi),
        .idx_o(idx_d), .mask_o(mask_d));

    always_comb begin
        fl_d.any        = |res;
        fl_d.pat_short  = p_short;
        fl_d.subj_short = s_short;
        fl_d.lsb        = res[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_o <= 1'b0;
            out_index_o <= '0;
            out_mask_o  <= '0;
            fl_q        <= '0;
            cq          <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                out_index_o <= idx_d;
                out_mask_o  <= mask_d;
                fl_q        <= fl_d;
                cq          <= c;
            end
        end
    end

    assign out_flags_o = fl_q;

    // R9: an empty result reports the character count as index
    p_idx_none_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !cq.fmt_mask && !fl_q.any) |->
            (out_index_o == (cq.wide ? IDX_W'(NW) : IDX_W'(NB))));

    // R9: any hit gives an index inside the operand
    p_idx_hit_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !cq.fmt_mask && fl_q.any) |->
            (out_index_o < (cq.wide ? IDX_W'(NW) : IDX_W'(NB))));

    // R10, R11: mask contents agree with the summary flags
    p_mask_any_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && cq.fmt_mask) |-> ((|out_mask_o) == fl_q.any));

    p_mask_lsb_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && cq.fmt_mask && !cq.sel_hi) |-> (out_mask_o[0] == fl_q.lsb));

    // R2, R3: valid characters always form a prefix of the operand
    p_prefix_r2: assert property (@(posedge clk) disable iff (rst)
        ((pv & (pv + 1'b1)) == '0) && ((sv & (sv + 1'b1)) == '0));

    // R12: outputs hold while no request arrives
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> ($stable(out_index_o) && $stable(out_mask_o) && $stable(out_flags_o)));

endmodule

// File: tb/strcmp_unit_tb.sv
module strcmp_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [7:0]   ctrl;
    logic         use_len;
    logic [127:0] pat, subj;
    logic [4:0]   pat_len, subj_len;
    logic         out_valid;
    logic [4:0]   out_index;
    logic [127:0] out_mask;
    logic [3:0]   out_flags;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strcmp_unit u_dut (
        .clk(clk), .rst(rst), .in_valid_i(in_valid), .ctrl_i(ctrl), .use_len_i(use_len),
        .pat_i(pat), .pat_len_i(pat_len), .subj_i(subj), .subj_len_i(subj_len),
        .out_valid_o(out_valid), .out_index_o(out_index), .out_mask_o(out_mask),
        .out_flags_o(out_flags));

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pk(input string t);
        logic [127:0] r = '0;
        for (int i = 0; i < t.len() && i < 16; i++) r[8*i +: 8] = t[i];
        return r;
    endfunction

    // Behavioural model written from the requirement text.
    function automatic logic [15:0] model(input logic [7:0] c, input logic [127:0] p,
                                          input logic [127:0] s, input logic ul,
                                          input int pl, input int sl,
                                          output bit ps, output bit ss);
        int n, plen, slen, mode;
        int pch[16];
        int sch[16];
        logic [15:0] r;
        n = c[0] ? 8 : 16;
        mode = int'(c[3:2]);
        for (int i = 0; i < 16; i++) begin pch[i] = 0; sch[i] = 0; end
        for (int i = 0; i < n; i++) begin
            pch[i] = c[0] ? int'(p[16*i +: 16]) : int'(p[8*i +: 8]);
            sch[i] = c[0] ? int'(s[16*i +: 16]) : int'(s[8*i +: 8]);
        end
        if (ul) begin
            plen = (pl > n) ? n : pl;
            slen = (sl > n) ? n : sl;
        end else begin
            plen = n; slen = n;
            for (int i = n - 1; i >= 0; i--) begin
                if (pch[i] == 0) plen = i;
                if (sch[i] == 0) slen = i;
            end
        end
        if (c[1]) begin
            for (int i = 0; i < n; i++) begin
                if (c[0]) begin
                    if (pch[i] >= 32768) pch[i] -= 65536;
                    if (sch[i] >= 32768) sch[i] -= 65536;
                end else begin
                    if (pch[i] >= 128) pch[i] -= 256;
                    if (sch[i] >= 128) sch[i] -= 256;
                end
            end
        end
        r = '0;
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: for (int j = 0; j < plen; j++)
                       if (i < slen && sch[i] == pch[j]) r[i] = 1'b1;
                1: for (int j = 0; j + 1 < plen; j += 2)
                       if (i < slen && pch[j] <= sch[i] && sch[i] <= pch[j+1]) r[i] = 1'b1;
                2: begin
                       if ((i < slen) != (i < plen)) r[i] = 1'b0;
                       else if (i >= slen)           r[i] = 1'b1;
                       else                          r[i] = (sch[i] == pch[i]);
                   end
                default: begin
                       r[i] = 1'b1;
                       for (int k = 0; k < plen && i + k < n; k++)
                           if (i + k >= slen || sch[i+k] != pch[k]) r[i] = 1'b0;
                   end
            endcase
        end
        if (c[4]) begin
            for (int i = 0; i < n; i++)
                if (!c[5] || i < slen) r[i] = ~r[i];
        end
        ps = plen < n;
        ss = slen < n;
        return r;
    endfunction

    // One request, then compare every output with the model.
    task automatic op(input string tag, input logic [7:0] c, input logic [127:0] p,
                      input logic [127:0] s, input logic ul, input int pl, input int sl);
        logic [15:0]  r;
        bit           ps, ss;
        int           n, ei;
        logic [127:0] em;
        r = model(c, p, s, ul, pl, sl, ps, ss);
        n = c[0] ? 8 : 16;
        ei = 0; em = '0;
        if (!c[7]) begin
            ei = n;
            if (c[6]) begin for (int i = 0; i < n; i++) if (r[i]) ei = i; end
            else      begin for (int i = n - 1; i >= 0; i--) if (r[i]) ei = i; end
        end else if (!c[6]) begin
            em[15:0] = r;
        end else begin
            for (int i = 0; i < n; i++)
                if (r[i]) begin
                    if (c[0]) em[16*i +: 16] = '1; else em[8*i +: 8] = '1;
                end
        end
        @(negedge clk);
        in_valid = 1'b1; ctrl = c; pat = p; subj = s; use_len = ul;
        pat_len = 5'(pl); subj_len = 5'(sl);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R12 valid"}, 128'(out_valid), 128'd1);
        chk({tag, " index"}, 128'(out_index), 128'(ei));
        chk({tag, " mask"}, out_mask, em);
        chk({tag, " R11 flags"}, 128'(out_flags), 128'({r[0], ss, ps, |r}));
    endtask

    task automatic t_reset;
        chk("R12 reset valid", 128'(out_valid), 128'd0);
        chk("R12 reset index", 128'(out_index), 128'd0);
        chk("R12 reset mask", out_mask, 128'd0);
        chk("R12 reset flags", 128'(out_flags), 128'd0);
    endtask

    task automatic t_set;
        op("R4 R3 set first", 8'h00, pk("aeiou"), pk("hello world"), 1'b0, 0, 0);
        chk("R9 first hit", 128'(out_index), 128'd1);
        chk("R11 short flags", 128'(out_flags), 128'h7);
        op("R4 R9 set last", 8'h40, pk("aeiou"), pk("hello world"), 1'b0, 0, 0);
        chk("R9 last hit", 128'(out_index), 128'd7);
        op("R4 R10 set packed", 8'h80, pk("aeiou"), pk("hello world"), 1'b0, 0, 0);
        chk("R10 packed", out_mask, 128'h0092);
    endtask

    task automatic t_range;
        op("R5 range letters", 8'h84, pk("azAZ"), pk("Ab1-x"), 1'b0, 0, 0);
        chk("R5 letters mask", out_mask, 128'h13);
        op("R5 signed", 8'h86, 128'h1080, 128'h200590, 1'b1, 2, 3);
        chk("R5 signed mask", out_mask, 128'h3);
        op("R5 unsigned", 8'h84, 128'h1080, 128'h200590, 1'b1, 2, 3);
        chk("R5 unsigned mask", out_mask, 128'h0);
    endtask

    task automatic t_pos;
        op("R6 R2 positional", 8'h88, pk("abcde"), pk("abXde"), 1'b1, 5, 5);
        chk("R6 equal lengths", out_mask, 128'hFFFB);
        op("R6 R2 short pattern", 8'h88, pk("abcde"), pk("abXde"), 1'b1, 3, 5);
        chk("R6 one side invalid", out_mask, 128'hFFE3);
        op("R2 clamp", 8'h88, pk("0123456789ABCDEF"), pk("0123456789ABCDEF"), 1'b1, 31, 31);
        chk("R2 clamp mask", out_mask, 128'hFFFF);
        chk("R2 clamp flags", 128'(out_flags), 128'h9);
    endtask

    task automatic t_sub;
        op("R7 middle", 8'h0C, pk("abc"), pk("zzabcz"), 1'b0, 0, 0);
        chk("R7 middle index", 128'(out_index), 128'd2);
        op("R7 middle mask", 8'h8C, pk("abc"), pk("zzabcz"), 1'b0, 0, 0);
        chk("R7 mask", out_mask, 128'h4);
        op("R7 tail", 8'h0C, pk("abc"), pk("0123456789ABCDab"), 1'b0, 0, 0);
        chk("R7 tail index", 128'(out_index), 128'd14);
    endtask

    task automatic t_wide;
        op("R1 wide hit", 8'h01, 128'h5678_1234, 128'h5678_2222_1111, 1'b0, 0, 0);
        chk("R1 wide index", 128'(out_index), 128'd2);
        op("R1 R9 wide none", 8'h01, 128'h5678_1234, 128'h1111, 1'b0, 0, 0);
        chk("R9 wide none", 128'(out_index), 128'd8);
        op("R10 wide expanded", 8'hC1, 128'h5678_1234, 128'h5678_2222_1111, 1'b0, 0, 0);
        chk("R10 wide expanded mask", out_mask, 128'hFFFF_0000_0000);
        op("R10 byte expanded", 8'hC0, pk("aeiou"), pk("hello world"), 1'b0, 0, 0);
        chk("R10 byte expanded mask", out_mask, 128'hFF00_00FF_0000_FF00);
    endtask

    task automatic t_pol;
        op("R8 invert all", 8'h90, pk("aeiou"), pk("hello world"), 1'b0, 0, 0);
        chk("R8 invert all mask", out_mask, 128'hFF6D);
        op("R8 invert valid", 8'hB0, pk("aeiou"), pk("hello world"), 1'b0, 0, 0);
        chk("R8 invert valid mask", out_mask, 128'h076D);
        op("R8 R9 empty valid-only", 8'h30, pk("aeiou"), 128'h0, 1'b0, 0, 0);
        chk("R9 empty count", 128'(out_index), 128'd16);
        op("R8 R9 empty invert all", 8'h10, pk("aeiou"), 128'h0, 1'b0, 0, 0);
        chk("R9 empty inverted", 128'(out_index), 128'd0);
    endtask

    task automatic t_hold;
        logic [4:0] idx0;
        op("R12 before hold", 8'h00, pk("aeiou"), pk("hello world"), 1'b0, 0, 0);
        idx0 = out_index;
        @(negedge clk);
        ctrl = 8'h40; subj = pk("zzzo"); pat = pk("o");
        repeat (3) @(negedge clk);
        chk("R12 idle valid", 128'(out_valid), 128'd0);
        chk("R12 idle hold", 128'(out_index), 128'(idx0));
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; ctrl = '0; use_len = 1'b0;
        pat = '0; subj = '0; pat_len = '0; subj_len = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set();
        t_range();
        t_pos();
        t_sub();
        t_wide();
        t_pol();
        t_hold();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule